// File: doc/BRIEF.md
# Latched-Reload PWM Generator

This block produces a single pulse-width modulated output whose average level follows an 8-bit duty value. After an external RC filter, it serves as a simple digital-to-analog converter. A free-running counter advances on a state-time enable pulse. An optional divide-by-two prescaler can halve that rate. The output is high from the start of each period until the counter reaches the active compare value, and low for the rest of the period.

Software writes a new duty value into a holding latch through a small register write port. The compare register copies that latch only when the counter wraps. A value written mid-period therefore never cuts short or skips an edge in the current period. A compare value of zero keeps the output low for the whole period. The same write port carries a control word whose bit 0 turns the prescaler on.

Top module: `latched_pwm`

## Requirements
- R1: After reset the holding latch, the compare register, the counter and the prescaler bit are all zero. The output is low and stays low while no duty value has been written.
- R2: While the compare register holds 0, the output is low for the entire period.
- R3: With compare value D, the output is high while the counter is below D and low from D up to the wrap. Each period of 256 counter steps therefore has exactly D high steps, including D = 1 and D = 255.
- R4: A duty value written in the middle of a period leaves that period's high time unchanged. The new value governs the period that starts after the next wrap.
- R5: With the prescaler off, the counter advances by one on each cycle where tick is 1. It holds its value, and the output holds its level, on cycles where tick is 0.
- R6: With the prescaler on, the counter advances on every second tick. One period therefore spans 512 ticks and contains 2·D high ticks.
- R7: A write with wr_sel = 0 loads wr_data into the holding latch. A write with wr_sel = 1 loads wr_data bit 0 into the prescaler bit (1 = halve the rate). Other bits of a control write have no effect.
- R8: The compare register changes only on the step where the counter wraps from 255 to 0. At that step it takes the latch value held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | State-time enable; one counting opportunity per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = duty latch, 1 = control word |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions assume that every input has a known value once reset is released. They also assume that tick may take any pattern, including long runs of zeros and back-to-back ones, and that writes of either kind may land on any counter value, including the wrap step itself. The stimulus keeps to this: tick is randomised at roughly 70 percent density, and duty and control writes are scattered at random. Directed periods with tick held high align the duty writes to mid-period and to the wrap, so the reload timing and the zero, one and full-scale duty values are reached deliberately.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic {
        SEL_DUTY = 1'b0,
        SEL_CTRL = 1'b1
    } pwm_sel_e;

    localparam int CTRL_PRE_BIT = 0;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] duty_latch,
    output logic             pre_en
);
    import pwm_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] latch;
        logic             pre;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (pwm_sel_e'(wr_sel) == SEL_DUTY) s_d.latch = wr_data;
            else                                 s_d.pre   = wr_data[CTRL_PRE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign duty_latch = s_q.latch;
    assign pre_en     = s_q.pre;
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter bit HAS_PRESCALE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pre_en,
    output logic adv
);
    generate
        if (HAS_PRESCALE) begin : g_div
            logic ph_d, ph_q;

            always_comb begin
                ph_d = ph_q;
                if (!pre_en)   ph_d = 1'b0;
                else if (tick) ph_d = ~ph_q;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) ph_q <= 1'b0;
                else        ph_q <= ph_d;
            end

            assign adv = tick && (!pre_en || ph_q);
        end else begin : g_nodiv
            logic unused_ok;
            assign unused_ok = clk ^ rst_n ^ pre_en;
            assign adv = tick;
        end
    endgenerate
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (adv) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt  = s_q.cnt;
    assign wrap = adv && (s_q.cnt == CNT_MAX);
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [CNT_W-1:0] duty_latch,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp,
    output logic             pwm_out
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
    } cmp_t;

    cmp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wrap) s_d.cmp = duty_latch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmp     = s_q.cmp;
    assign pwm_out = (s_q.cmp != '0) && (cnt < s_q.cmp);
endmodule

// File: rtl/latched_pwm.sv
module latched_pwm #(
    parameter int CNT_W        = 8,
    parameter bit HAS_PRESCALE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out
);
    logic [CNT_W-1:0] latch_w, cnt_w, cmp_w;
    logic             pre_w, adv_w, wrap_w;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .duty_latch(latch_w), .pre_en(pre_w)
    );

    pwm_prescale #(.HAS_PRESCALE(HAS_PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pre_en(pre_w), .adv(adv_w)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv_w), .cnt(cnt_w), .wrap(wrap_w)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .wrap(wrap_w), .duty_latch(latch_w),
        .cnt(cnt_w), .cmp(cmp_w), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             pre,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             pwm_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_zero_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp == '0) |-> !pwm_out);

    p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && cmp != '0) |-> pwm_out);

    p_low_from_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= cmp) |-> !pwm_out);

    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && $stable(pwm_out)));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pre) |=> (cnt == $past(cnt) + 1'b1));

    p_reload_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp) |-> ($past(cnt) == CNT_MAX && cnt == '0));
endmodule

bind latched_pwm pwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pre(pre_w),
    .cnt(cnt_w), .cmp(cmp_w), .pwm_out(pwm_out)
);

// File: tb/sim_latched_pwm.sv
module sim_latched_pwm;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // bench reference state
    logic [7:0] m_cnt = 0, m_cmp = 0, m_lat = 0;
    logic       m_pre = 0, m_ph = 0;
    logic       last_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_pwm u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    function automatic logic exp_out();
        return (m_cmp != 0) && (m_cnt < m_cmp);
    endfunction

    task automatic check(input logic act, input logic expv, input string tag);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: pwm_out actual=%0b expected=%0b (t=%0t)", tag, act, expv, $time);
        end
    endtask

    task automatic check_int(input int act, input int expv, input string tag);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic model_step(input logic t, input logic w, input logic s, input logic [7:0] d);
        logic adv;
        logic wrap;
        adv  = t && (!m_pre || m_ph);
        wrap = adv && (m_cnt == 8'hFF);
        if (!m_pre) m_ph = 1'b0;
        else if (t) m_ph = ~m_ph;
        if (wrap) m_cmp = m_lat;
        if (adv) m_cnt = m_cnt + 8'd1;
        if (w && !s) m_lat = d;
        if (w && s)  m_pre = d[0];
    endtask

    task automatic step(input logic t, input logic w, input logic s,
                        input logic [7:0] d, input string tag);
        @(negedge clk);
        last_out = pwm_out;
        check(pwm_out, exp_out(), tag);
        tick = t; wr_en = w; wr_sel = s; wr_data = d;
        model_step(t, w, s, d);
    endtask

    task automatic align(input string tag);
        do step(1, 0, 0, 0, tag); while (m_cnt != 0 || m_ph != 0);
    endtask

    task automatic measure(input int steps, input int expv, input string tag);
        int hi = 0;
        for (int i = 0; i < steps; i++) begin
            step(1, 0, 0, 0, tag);
            hi += last_out;
        end
        check_int(hi, expv, tag);
    endtask

    task automatic load_duty(input logic [7:0] d);
        step(1, 1, 0, d, "R7");
        align("R8");
    endtask

    initial begin
        int seed = 32'd1234;
        void'($urandom(seed));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(pwm_out, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: no duty written, full period stays low
        align("R1");
        measure(256, 0, "R1");
        // R3: duty 1, 255, 128
        load_duty(8'd1);
        measure(256, 1, "R3");
        load_duty(8'd255);
        measure(256, 255, "R3");
        load_duty(8'd128);
        measure(256, 128, "R3");
        // R2: duty 0 after nonzero
        load_duty(8'd0);
        measure(256, 0, "R2");
        // R4: mid-period write keeps current period
        load_duty(8'd200);
        begin
            int hi = 0;
            for (int i = 0; i < 256; i++) begin
                step(1, (i == 50), 0, 8'd10, "R4");
                hi += last_out;
            end
            check_int(hi, 200, "R4");
        end
        measure(256, 10, "R4");
        // R8: write on the wrap step itself; old latch reloads
        load_duty(8'd60);
        for (int i = 0; i < 255; i++) step(1, 0, 0, 0, "R8");
        step(1, 1, 0, 8'd90, "R8");
        measure(256, 60, "R8");
        measure(256, 90, "R8");
        // R5: no ticks hold output level
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0, "R5");
        for (int i = 0; i < 30; i++) step(0, 0, 0, 0, "R5");
        // R6/R7: prescaler on, extra control bits ignored
        step(0, 1, 1, 8'hFE, "R7");
        check_int(m_pre, 0, "R7");
        step(0, 1, 1, 8'h01, "R7");
        align("R6");
        measure(512, 180, "R6");
        step(0, 1, 1, 8'h00, "R7");
        align("R7");
        measure(256, 90, "R7");
        // random mix, checked every cycle against the bench model (R5)
        for (int i = 0; i < 30000; i++) begin
            logic t, w, s;
            logic [7:0] d;
            t = ($urandom_range(0, 9) < 7);
            w = ($urandom_range(0, 99) < 4);
            s = ($urandom_range(0, 9) == 0);
            d = 8'($urandom);
            if ($urandom_range(0, 7) == 0) d = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'h00;
            step(t, w, s, d, "R5");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule